// File: doc/BRIEF.md
# Bus Controller Command Decoder and Interrupt Collector

This block is the command and interrupt front end of a small bus-controller core. Software reaches it through a byte-wide register port (address, write enable, read enable, write data, combinational read data). A byte written to the command register is decoded into single-cycle action strobes: no-op, FIFO flush, chip reset, attached-bus reset, and transfer-information start. The transfer strobe carries a programmed-I/O qualifier. The bus-phase sequencer and the data path sit outside the block. They appear here only as event inputs and as the strobe outputs.

Event inputs from the rest of the core set bits in an interrupt register. That register clears itself when software reads it. A status register reports a pending-interrupt summary, sticky gross-error and parity-error flags, and the live bus phase code. The interrupt pin follows the summary bit, gated by an enable bit in a configuration register. Two offsets are shared by direction: writes there load a destination-ID register and a timeout register, while reads return status and interrupt contents.

Top module: `bus_cmd_frontend`

## Requirements
- R1: After reset the command register reads 0x00, the interrupt and status registers read 0x00 (with bus phase input 0), every strobe is low and `irq` is low.
- R2: Reading offset 0x03 returns the last byte written to offset 0x03, including undefined codes. The exception is a chip-reset command, after which it reads 0x00.
- R3: A write to offset 0x03 whose low seven bits are 0x00, 0x01, 0x02 or 0x03 raises exactly one strobe (no-op, flush, chip reset, bus reset in that order) for the single cycle after the write. At all times at most one strobe is high.
- R4: A write to offset 0x03 whose low seven bits are 0x10 raises `strb_xfer` for one cycle. During that cycle `xfer_pio` equals bit 7 of the written byte, so 0x10 and 0x90 differ only in `xfer_pio`.
- R5: A write to offset 0x03 with any other low-seven-bit value raises no strobe. It sets bit 6 (illegal command) of the interrupt register.
- R6: Event inputs set interrupt bits as follows: bus reset bit 7, disconnect bit 5, bus service bit 4, function complete bit 3, reselected bit 2, and the two-bit selection code ORed into bits 1:0. Each set bit stays set until the register is read or a chip reset occurs.
- R7: A read of offset 0x05 returns the interrupt register and clears all of its bits. An event or illegal command arriving in the same cycle as the read is kept.
- R8: Status (read at offset 0x04) has the following layout. Bit 7 is 1 exactly when the interrupt register is nonzero. Bits 6 and 5 are sticky gross-error and parity-error flags. Bits 4:3 read 0. Bits 2:0 follow the bus phase input in the same cycle.
- R9: `irq` is high exactly when status bit 7 is set and bit 5 of the configuration register at offset 0x16 is set.
- R10: A write to offset 0x04 loads `dest_id` from the low three bits of the data. A write to offset 0x05 loads `tmo_val`. Neither write changes the status or interrupt registers.
- R11: A chip-reset command clears the interrupt register, both status error flags and the command register. This takes priority over any event in the same cycle. The configuration, destination-ID and timeout registers keep their values.
- R12: The configuration register at offset 0x16 reads back the byte last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register offset |
| wr_en | input | 1 | Write strobe for `addr` |
| rd_en | input | 1 | Read strobe for `addr` (clears the interrupt register at 0x05) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ev_bus_rst | input | 1 | Bus reset seen |
| ev_disc | input | 1 | Target disconnected |
| ev_svc | input | 1 | Bus service request |
| ev_done | input | 1 | Function complete |
| ev_resel | input | 1 | Reselected |
| ev_sel | input | 2 | Selection interrupt code |
| err_gross | input | 1 | Gross error pulse |
| err_parity | input | 1 | Parity error pulse |
| bus_phase | input | 3 | Current bus phase code |
| strb_nop | output | 1 | No-op strobe |
| strb_flush | output | 1 | FIFO flush strobe |
| strb_chip_rst | output | 1 | Chip reset strobe |
| strb_bus_rst | output | 1 | Attached-bus reset strobe |
| strb_xfer | output | 1 | Transfer-information start strobe |
| xfer_pio | output | 1 | Programmed-I/O qualifier for the strobe cycle |
| dest_id | output | 3 | Destination ID register |
| tmo_val | output | 8 | Timeout multiplier register |
| irq | output | 1 | Gated interrupt output |

## Verification
The bench builds the block with its default parameters: a five-bit address, a three-bit destination ID, and command, status/destination, interrupt/timeout and configuration offsets at 0x03, 0x04, 0x05 and 0x16. These values reach every defined command code with and without the programmed-I/O bit, as well as undefined codes. They also cover the direction-shared offsets and the enable bit of the interrupt gate. Because read data is combinational, the bench can also probe the same-cycle cases: an event arriving with an interrupt read, and an event arriving with a chip reset.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

    localparam int BYTE_W      = 8;
    localparam int CMD_PIO_BIT = 7;
    localparam int OP_W        = 7;
    localparam int PHASE_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 7'h00,
        OP_FLUSH    = 7'h01,
        OP_CHIP_RST = 7'h02,
        OP_BUS_RST  = 7'h03,
        OP_XFER     = 7'h10
    } op_e;

    // decoded command actions
    typedef struct packed {
        logic nop;
        logic flush;
        logic chip_rst;
        logic bus_rst;
        logic xfer;
        logic pio;
        logic illegal;
    } cmd_act_t;

    // interrupt register layout, msb first
    typedef struct packed {
        logic       bus_rst;
        logic       illegal;
        logic       disc;
        logic       svc;
        logic       done;
        logic       resel;
        logic [1:0] sel;
    } irq_reg_t;

    // status register layout, msb first
    typedef struct packed {
        logic               pend;
        logic               gross;
        logic               parity;
        logic [1:0]         rsv;
        logic [PHASE_W-1:0] phase;
    } stat_reg_t;

    function automatic cmd_act_t decode_cmd(input logic [BYTE_W-1:0] code);
        cmd_act_t a;
        a     = '0;
        a.pio = code[CMD_PIO_BIT];
        case (op_e'(code[OP_W-1:0]))
            OP_NOP:      a.nop      = 1'b1;
            OP_FLUSH:    a.flush    = 1'b1;
            OP_CHIP_RST: a.chip_rst = 1'b1;
            OP_BUS_RST:  a.bus_rst  = 1'b1;
            OP_XFER:     a.xfer     = 1'b1;
            default:     a.illegal  = 1'b1;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/bcf_cmd_decode.sv
module bcf_cmd_decode
    import bcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              illegal_now,
    output logic              chip_rst_now,
    output cmd_act_t          act_q,
    output logic [BYTE_W-1:0] cmd_reg
);
    cmd_act_t act_d;

    always_comb begin
        act_d        = decode_cmd(cmd_data);
        illegal_now  = cmd_wr && act_d.illegal;
        chip_rst_now = cmd_wr && act_d.chip_rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            cmd_reg <= '0;
        end else begin
            if (cmd_wr) begin
                act_q         <= act_d;
                act_q.illegal <= 1'b0;
                act_q.pio     <= act_d.pio && act_d.xfer;
            end else begin
                act_q <= '0;
            end
            if (chip_rst_now)
                cmd_reg <= '0;
            else if (cmd_wr)
                cmd_reg <= cmd_data;
        end
    end
endmodule

// File: rtl/bcf_irq_collect.sv
module bcf_irq_collect
    import bcf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  irq_reg_t           evt,
    input  logic               chip_rst_now,
    input  logic               int_rd,
    input  logic               err_gross,
    input  logic               err_parity,
    input  logic [PHASE_W-1:0] bus_phase,
    output irq_reg_t           int_reg,
    output stat_reg_t          status
);
    logic gross_q;
    logic parity_q;
    irq_reg_t int_d;

    always_comb begin
        int_d = int_rd ? irq_reg_t'('0) : int_reg;
        int_d = int_d | evt;
        if (chip_rst_now)
            int_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_reg  <= '0;
            gross_q  <= 1'b0;
            parity_q <= 1'b0;
        end else begin
            int_reg <= int_d;
            if (chip_rst_now) begin
                gross_q  <= 1'b0;
                parity_q <= 1'b0;
            end else begin
                gross_q  <= gross_q  | err_gross;
                parity_q <= parity_q | err_parity;
            end
        end
    end

    always_comb begin
        status        = '0;
        status.pend   = |int_reg;
        status.gross  = gross_q;
        status.parity = parity_q;
        status.phase  = bus_phase;
    end
endmodule

// File: rtl/bcf_reg_port.sv
module bcf_reg_port
    import bcf_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter int                ID_W     = 3,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 5'h03,
    parameter logic [ADDR_W-1:0] STAT_OFS = 5'h04,
    parameter logic [ADDR_W-1:0] INT_OFS  = 5'h05,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 5'h16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] cmd_reg,
    input  stat_reg_t         status,
    input  irq_reg_t          int_reg,
    output logic [BYTE_W-1:0] rdata,
    output logic              cmd_wr,
    output logic              int_rd,
    output logic [ID_W-1:0]   dest_id,
    output logic [BYTE_W-1:0] tmo_val,
    output logic [BYTE_W-1:0] cfg_reg
);
    always_comb begin
        cmd_wr = wr_en && (addr == CMD_OFS);
        int_rd = rd_en && (addr == INT_OFS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_id <= '0;
            tmo_val <= '0;
            cfg_reg <= '0;
        end else if (wr_en) begin
            if (addr == STAT_OFS) dest_id <= wdata[ID_W-1:0];
            if (addr == INT_OFS)  tmo_val <= wdata;
            if (addr == CFG_OFS)  cfg_reg <= wdata;
        end
    end

    always_comb begin
        if (addr == CMD_OFS)       rdata = cmd_reg;
        else if (addr == STAT_OFS) rdata = status;
        else if (addr == INT_OFS)  rdata = int_reg;
        else if (addr == CFG_OFS)  rdata = cfg_reg;
        else                       rdata = '0;
    end
endmodule

// File: rtl/bus_cmd_frontend.sv
module bus_cmd_frontend
    import bcf_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter int                ID_W     = 3,
    parameter int                IE_BIT   = 5,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 5'h03,
    parameter logic [ADDR_W-1:0] STAT_OFS = 5'h04,
    parameter logic [ADDR_W-1:0] INT_OFS  = 5'h05,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 5'h16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               ev_bus_rst,
    input  logic               ev_disc,
    input  logic               ev_svc,
    input  logic               ev_done,
    input  logic               ev_resel,
    input  logic [1:0]         ev_sel,
    input  logic               err_gross,
    input  logic               err_parity,
    input  logic [2:0]         bus_phase,
    output logic               strb_nop,
    output logic               strb_flush,
    output logic               strb_chip_rst,
    output logic               strb_bus_rst,
    output logic               strb_xfer,
    output logic               xfer_pio,
    output logic [ID_W-1:0]    dest_id,
    output logic [7:0]         tmo_val,
    output logic               irq
);
    logic              cmd_wr;
    logic              int_rd;
    logic              illegal_now;
    logic              chip_rst_now;
    cmd_act_t          act_q;
    logic [BYTE_W-1:0] cmd_reg;
    logic [BYTE_W-1:0] cfg_reg;
    irq_reg_t          evt;
    irq_reg_t          int_reg;
    stat_reg_t         status;

    always_comb begin
        evt         = '0;
        evt.bus_rst = ev_bus_rst;
        evt.illegal = illegal_now;
        evt.disc    = ev_disc;
        evt.svc     = ev_svc;
        evt.done    = ev_done;
        evt.resel   = ev_resel;
        evt.sel     = ev_sel;
    end

    bcf_reg_port #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .CMD_OFS(CMD_OFS),
        .STAT_OFS(STAT_OFS), .INT_OFS(INT_OFS), .CFG_OFS(CFG_OFS)
    ) u_port (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .cmd_reg(cmd_reg), .status(status), .int_reg(int_reg),
        .rdata(rdata), .cmd_wr(cmd_wr), .int_rd(int_rd), .dest_id(dest_id),
        .tmo_val(tmo_val), .cfg_reg(cfg_reg)
    );

    bcf_cmd_decode u_dec (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(wdata),
        .illegal_now(illegal_now), .chip_rst_now(chip_rst_now),
        .act_q(act_q), .cmd_reg(cmd_reg)
    );

    bcf_irq_collect u_irq (
        .clk(clk), .rst(rst), .evt(evt), .chip_rst_now(chip_rst_now),
        .int_rd(int_rd), .err_gross(err_gross), .err_parity(err_parity),
        .bus_phase(bus_phase), .int_reg(int_reg), .status(status)
    );

    always_comb begin
        strb_nop      = act_q.nop;
        strb_flush    = act_q.flush;
        strb_chip_rst = act_q.chip_rst;
        strb_bus_rst  = act_q.bus_rst;
        strb_xfer     = act_q.xfer;
        xfer_pio      = act_q.pio;
        irq           = status.pend && cfg_reg[IE_BIT];
    end
endmodule

// File: rtl/bus_cmd_frontend_chk.sv
module bus_cmd_frontend_chk #(
    parameter int                ADDR_W  = 5,
    parameter int                IE_BIT  = 5,
    parameter logic [ADDR_W-1:0] CMD_OFS = 5'h03,
    parameter logic [ADDR_W-1:0] INT_OFS = 5'h05
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        wdata,
    input logic              ev_any,
    input logic              strb_nop,
    input logic              strb_flush,
    input logic              strb_chip_rst,
    input logic              strb_bus_rst,
    input logic              strb_xfer,
    input logic              irq,
    input logic [7:0]        cmd_reg,
    input logic [7:0]        int_reg,
    input logic [7:0]        cfg_reg
);
    logic cw;
    logic known;
    logic rd_int;
    always_comb begin
        cw     = wr_en && (addr == CMD_OFS);
        known  = (wdata[6:0] == 7'h00) || (wdata[6:0] == 7'h01) ||
                 (wdata[6:0] == 7'h02) || (wdata[6:0] == 7'h03) ||
                 (wdata[6:0] == 7'h10);
        rd_int = rd_en && (addr == INT_OFS);
    end

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb_nop, strb_flush, strb_chip_rst, strb_bus_rst, strb_xfer}));

    a_r3_flush_strobe: assert property (@(posedge clk) disable iff (rst)
        (cw && wdata[6:0] == 7'h01) |=> strb_flush);

    a_r5_illegal_flag: assert property (@(posedge clk) disable iff (rst)
        (cw && !known) |=> int_reg[6]);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_int && !ev_any && !cw) |=> (int_reg == 8'h00));

    a_r6_sticky_svc: assert property (@(posedge clk) disable iff (rst)
        (int_reg[4] && !rd_int && !cw) |=> int_reg[4]);

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        !cfg_reg[IE_BIT] |-> !irq);

    a_r11_chip_reset: assert property (@(posedge clk) disable iff (rst)
        (cw && wdata[6:0] == 7'h02) |=> (cmd_reg == 8'h00 && int_reg == 8'h00));

    a_r2_readback: assert property (@(posedge clk) disable iff (rst)
        (cw && wdata[6:0] != 7'h02) |=> (cmd_reg == $past(wdata)));
endmodule

bind bus_cmd_frontend bus_cmd_frontend_chk #(
    .ADDR_W(ADDR_W), .IE_BIT(IE_BIT), .CMD_OFS(CMD_OFS), .INT_OFS(INT_OFS)
) i_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata),
    .ev_any(ev_bus_rst | ev_disc | ev_svc | ev_done | ev_resel | (|ev_sel)),
    .strb_nop(strb_nop), .strb_flush(strb_flush), .strb_chip_rst(strb_chip_rst),
    .strb_bus_rst(strb_bus_rst), .strb_xfer(strb_xfer), .irq(irq),
    .cmd_reg(cmd_reg), .int_reg(int_reg), .cfg_reg(cfg_reg)
);

// File: tb/test_bus_cmd_frontend.sv
module test_bus_cmd_frontend;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ev_bus_rst = 0, ev_disc = 0, ev_svc = 0, ev_done = 0, ev_resel = 0;
    logic [1:0] ev_sel = '0;
    logic       err_gross = 0, err_parity = 0;
    logic [2:0] bus_phase = '0;
    logic       strb_nop, strb_flush, strb_chip_rst, strb_bus_rst, strb_xfer, xfer_pio;
    logic [2:0] dest_id;
    logic [7:0] tmo_val;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [4:0] A_CMD = 5'h03, A_STAT = 5'h04, A_INT = 5'h05, A_CFG = 5'h16;

    always #4 clk = ~clk;

    bus_cmd_frontend i_bus_cmd_frontend (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ev_bus_rst(ev_bus_rst), .ev_disc(ev_disc),
        .ev_svc(ev_svc), .ev_done(ev_done), .ev_resel(ev_resel), .ev_sel(ev_sel),
        .err_gross(err_gross), .err_parity(err_parity), .bus_phase(bus_phase),
        .strb_nop(strb_nop), .strb_flush(strb_flush), .strb_chip_rst(strb_chip_rst),
        .strb_bus_rst(strb_bus_rst), .strb_xfer(strb_xfer), .xfer_pio(xfer_pio),
        .dest_id(dest_id), .tmo_val(tmo_val), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    function automatic logic [4:0] strobes();
        return {strb_nop, strb_flush, strb_chip_rst, strb_bus_rst, strb_xfer};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        check(strobes() == 0 && irq == 0, "R1 strobes/irq", {strobes(), irq}, 0);
        rd(A_CMD, v);  check(v == 8'h00, "R1 cmd", v, 0);
        rd(A_INT, v);  check(v == 8'h00, "R1 int", v, 0);
        rd(A_STAT, v); check(v == 8'h00, "R1 status", v, 0);
    endtask

    task automatic t_decode();
        logic [7:0] codes [4] = '{8'h00, 8'h01, 8'h82, 8'h03};
        logic [4:0] exp;
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            wr(A_CMD, codes[i]);
            exp = 5'b10000 >> i;
            check(strobes() == exp, "R3 strobe", strobes(), exp);
            @(posedge clk); #1;
            check(strobes() == 0, "R3 single cycle", strobes(), 0);
        end
        rd(A_INT, v);
        check(v == 8'h00, "R5 legal codes raise nothing", v, 0);
    endtask

    task automatic t_xfer();
        wr(A_CMD, 8'h10);
        check(strb_xfer && !xfer_pio, "R4 xfer plain", {strb_xfer, xfer_pio}, 2'b10);
        wr(A_CMD, 8'h90);
        check(strb_xfer && xfer_pio, "R4 xfer pio", {strb_xfer, xfer_pio}, 2'b11);
        @(posedge clk); #1;
        check(!strb_xfer && !xfer_pio, "R4 one cycle", {strb_xfer, xfer_pio}, 0);
    endtask

    task automatic t_illegal();
        logic [7:0] v;
        wr(A_CMD, 8'hFF);
        check(strobes() == 0, "R5 no strobe", strobes(), 0);
        rd(A_CMD, v);  check(v == 8'hFF, "R2 readback", v, 8'hFF);
        rd(A_STAT, v); check(v[7] == 1'b1, "R8 pending", v, 8'h80);
        check(irq == 1'b0, "R9 gated off", irq, 0);
        wr(A_CFG, 8'h20);
        check(irq == 1'b1, "R9 gated on", irq, 1);
        rd(A_CFG, v);  check(v == 8'h20, "R12 cfg readback", v, 8'h20);
        rd(A_INT, v);  check(v == 8'h40, "R5 illegal bit", v, 8'h40);
        check(irq == 1'b0, "R7 irq falls after read", irq, 0);
        rd(A_INT, v);  check(v == 8'h00, "R7 cleared", v, 0);
    endtask

    task automatic t_events();
        logic [7:0] v;
        @(negedge clk);
        ev_bus_rst = 1; ev_disc = 1; ev_resel = 1; ev_sel = 2'b01;
        @(posedge clk); #1;
        ev_bus_rst = 0; ev_disc = 0; ev_resel = 0; ev_sel = 2'b10;
        ev_svc = 1; ev_done = 1;
        @(posedge clk); #1;
        ev_sel = 0; ev_svc = 0; ev_done = 0;
        repeat (3) @(posedge clk);
        #1;
        rd(A_INT, v); check(v == 8'hBF, "R6 event bits", v, 8'hBF);
    endtask

    task automatic t_race();
        logic [7:0] v;
        @(negedge clk);
        ev_done = 1;
        @(posedge clk); #1 ev_done = 0;
        @(negedge clk);
        addr = A_INT; rd_en = 1; ev_svc = 1;
        #1 v = rdata;
        @(posedge clk); #1;
        rd_en = 0; ev_svc = 0;
        check(v == 8'h08, "R7 read value", v, 8'h08);
        rd(A_INT, v); check(v == 8'h10, "R7 same-cycle event kept", v, 8'h10);
    endtask

    task automatic t_status();
        logic [7:0] v;
        bus_phase = 3'b101;
        @(negedge clk); err_gross = 1;
        @(posedge clk); #1 err_gross = 0;
        @(negedge clk); err_parity = 1;
        @(posedge clk); #1 err_parity = 0;
        rd(A_STAT, v); check(v == 8'h65, "R8 status layout", v, 8'h65);
        bus_phase = 3'b010;
        rd(A_STAT, v); check(v == 8'h62, "R8 sticky errors, live phase", v, 8'h62);
    endtask

    task automatic t_shared();
        logic [7:0] v;
        wr(A_STAT, 8'hFE);
        check(dest_id == 3'd6, "R10 dest id", dest_id, 6);
        wr(A_INT, 8'h99);
        check(tmo_val == 8'h99, "R10 timeout", tmo_val, 8'h99);
        rd(A_INT, v);  check(v == 8'h00, "R10 int untouched", v, 0);
        rd(A_STAT, v); check(v == 8'h62, "R10 status untouched", v, 8'h62);
    endtask

    task automatic t_chip_rst();
        logic [7:0] v;
        wr(A_CMD, 8'h7E);
        @(negedge clk);
        addr = A_CMD; wdata = 8'h02; wr_en = 1; ev_disc = 1; ev_sel = 2'b11;
        @(posedge clk); #1;
        wr_en = 0; ev_disc = 0; ev_sel = 0;
        check(strb_chip_rst, "R11 strobe", strb_chip_rst, 1);
        check(irq == 0, "R11 irq low", irq, 0);
        rd(A_INT, v);  check(v == 8'h00, "R11 int cleared over event", v, 0);
        bus_phase = 3'b000;
        rd(A_STAT, v); check(v == 8'h00, "R11 status cleared", v, 0);
        rd(A_CMD, v);  check(v == 8'h00, "R11 cmd cleared", v, 0);
        rd(A_CFG, v);  check(v == 8'h20, "R11 cfg kept", v, 8'h20);
        check(dest_id == 3'd6 && tmo_val == 8'h99, "R11 dest/timeout kept",
              {dest_id, tmo_val}, {3'd6, 8'h99});
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst = 1'b0;
                t_reset();
                t_decode();
                t_xfer();
                t_illegal();
                t_events();
                t_race();
                t_status();
                t_shared();
                t_chip_rst();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule